// File: doc/BRIEF.md
# Twin-Clock Dual-Port RAM with Per-Port Output Latency

This block is a two-port synchronous memory with 9-bit words by default. Each port runs on its own clock and can read or write any word, and both ports may touch the same word. A port samples its address, write data, write strobe and a pair of enables on its rising clock edge. The port acts only when the active-low enable is low and the active-high enable is high.

Each port has a static mode input that sets its read latency. In flow-through mode the read word appears right after the edge that sampled the address. In pipelined mode it appears one edge later, and the enables pass through a second register stage, so both dropping and regaining the output drive take two edges. Bidirectional pins are not used. Each port instead has a read data bus and a drive flag that marks when the data would be actively driven. An active-low output enable clears the drive flag at once, with no clock edge needed.

The storage is one bank per port plus a one-bit last-writer mark per word in each bank. This keeps every array with a single writer, even though the two ports write on unrelated clocks.

Top module: `twinclk_ram`

## Requirements
- R1: A port is selected only when its active-low enable is 0 and its active-high enable is 1. With the encodings (1,1), (0,0) or (1,0), a write strobe leaves memory unchanged and the port does not drive after that edge.
- R2: On a selected edge, a write strobe of 0 stores the write data at the sampled address. A write strobe of 1 reads that address.
- R3: With the mode input at 0 (flow-through), a read sampled at an edge drives its word from that edge until the next one.
- R4: With the mode input at 1 (pipelined), a read sampled at an edge drives its word only after the following edge.
- R5: In flow-through mode, deselecting or reselecting changes the drive flag after one edge. In pipelined mode it takes two edges.
- R6: While the output enable is 1, the drive flag is 0 and the read data bus is zero, without waiting for any clock edge.
- R7: The drive state in a cycle follows the previous cycle's controls: a write cycle gives no drive in the cycle that follows it, one edge later in flow-through mode and two edges later in pipelined mode.
- R8: Whenever the drive flag is 0, the read data bus is all zeros.
- R9: A word written by one port is returned by a read on the other port whose edge comes after the write edge. Both ports may read the same word concurrently.
- R10: During reset, both drive flags are 0 and both read data buses are zero.
- R11: The mode input acts without a clock. Changing it mid-cycle at once switches the output between the latest read word and the word from the read before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A active-low reset |
| a_en_lo_n | input | 1 | Port A enable, active low |
| a_en_hi | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A write strobe (0 write, 1 read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A mode (0 flow-through, 1 pipelined), static |
| a_rdata | output | DATA_W | Port A read data, zero when not driven |
| a_drive | output | 1 | Port A drive flag |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B active-low reset |
| b_en_lo_n | input | 1 | Port B enable, active low |
| b_en_hi | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B write strobe (0 write, 1 read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B mode (0 flow-through, 1 pipelined), static |
| b_rdata | output | DATA_W | Port B read data, zero when not driven |
| b_drive | output | 1 | Port B drive flag |

## Verification
The bench fills every word from one port and reads all of them back in flow-through mode on that port and in pipelined mode on the other. A latency that is off by one edge shows up as the neighbouring word's pattern, or as a missing drive on the first or last read. It probes the one-edge and two-edge deselect and reselect windows and writes under each of the three deselecting enable encodings. A design that decoded the enables wrongly would corrupt a word or drive when it should not. Mid-cycle toggles of the output enable and the mode input catch any design that registers those inputs. Writes on one port followed by reads on the other catch a last-writer selection that picks the stale bank.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

   typedef enum logic {
      MODE_FLOW = 1'b0,
      MODE_PIPE = 1'b1
   } out_mode_e;

   // both enables must agree for a port to act
   function automatic logic chip_selected(input logic lo_n, input logic hi);
      return (!lo_n) && hi;
   endfunction

endpackage

// File: rtl/tcr_store.sv
module tcr_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 9
) (
   input  logic [1:0]             clk_v,
   input  logic [1:0]             we_v,
   input  logic [1:0][ADDR_W-1:0] addr_v,
   input  logic [1:0][DATA_W-1:0] wdata_v,
   output logic [1:0][DATA_W-1:0] rdata_v
);
   localparam int DEPTH = 1 << ADDR_W;

   // one bank and one mark per writer; the marks form a last-writer table
   logic [DATA_W-1:0] bank_a [DEPTH];
   logic [DATA_W-1:0] bank_b [DEPTH];
   logic              mark_a [DEPTH];
   logic              mark_b [DEPTH];

   // port 0 makes the marks equal, port 1 makes them differ
   always_ff @(posedge clk_v[0]) begin
      if (we_v[0]) begin
         bank_a[addr_v[0]] <= wdata_v[0];
         mark_a[addr_v[0]] <= mark_b[addr_v[0]];
      end
   end

   always_ff @(posedge clk_v[1]) begin
      if (we_v[1]) begin
         bank_b[addr_v[1]] <= wdata_v[1];
         mark_b[addr_v[1]] <= !mark_a[addr_v[1]];
      end
   end

   generate
      for (genvar p = 0; p < 2; p++) begin : g_rd
         logic a_won;
         always_comb begin
            a_won      = (mark_a[addr_v[p]] == mark_b[addr_v[p]]);
            rdata_v[p] = a_won ? bank_a[addr_v[p]] : bank_b[addr_v[p]];
         end
      end
   endgenerate

endmodule

// File: rtl/tcr_port.sv
module tcr_port
   import tcr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lo_n,
   input  logic              en_hi,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              oe_n,
   input  logic              pipe,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              drive
);
   logic              port_sel;
   logic              wr_go;
   logic              rd_go;
   logic              rd_en1;
   logic              rd_en2;
   logic [DATA_W-1:0] rd_q;
   logic [DATA_W-1:0] rd_p;
   logic              drive_raw;
   logic [DATA_W-1:0] data_raw;
   out_mode_e         mode;

   assign mode      = out_mode_e'(pipe);
   assign port_sel  = chip_selected(en_lo_n, en_hi);
   assign wr_go     = port_sel && !wr_n;
   assign rd_go     = port_sel && wr_n;
   assign mem_we    = wr_go;
   assign mem_addr  = addr;
   assign mem_wdata = wdata;

   // first stage: enable and captured word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en1 <= 1'b0;
         rd_q   <= '0;
      end else begin
         rd_en1 <= rd_go;
         if (rd_go) rd_q <= mem_rdata;
      end
   end

   // second stage, used only in pipelined mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en2 <= 1'b0;
         rd_p   <= '0;
      end else begin
         rd_en2 <= rd_en1;
         rd_p   <= rd_q;
      end
   end

   // mode and output enable act without a clock
   always_comb begin
      if (mode == MODE_PIPE) begin
         drive_raw = rd_en2;
         data_raw  = rd_p;
      end else begin
         drive_raw = rd_en1;
         data_raw  = rd_q;
      end
      drive = drive_raw && !oe_n;
      rdata = drive ? data_raw : '0;
   end

   AST_FT_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_sel && !pipe) |=> (pipe || !drive)); // R5
   AST_PIPE_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_sel && pipe) |=> ##1 (!pipe || !drive)); // R5
   AST_FT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !pipe) |=> (pipe || !drive)); // R7
   AST_FT_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !pipe && !oe_n) |=> (pipe || oe_n || drive)); // R3
   AST_PIPE_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && pipe) |=> ##1 (!pipe || oe_n || drive)); // R4

endmodule

// File: rtl/twinclk_ram.sv
module twinclk_ram
   import tcr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 9
) (
   input  logic              a_clk,
   input  logic              a_rst_n,
   input  logic              a_en_lo_n,
   input  logic              a_en_hi,
   input  logic              a_wr_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              a_oe_n,
   input  logic              a_pipe,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_drive,
   input  logic              b_clk,
   input  logic              b_rst_n,
   input  logic              b_en_lo_n,
   input  logic              b_en_hi,
   input  logic              b_wr_n,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic              b_oe_n,
   input  logic              b_pipe,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_drive
);
   localparam int NPORT = 2;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("twinclk_ram: ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("twinclk_ram: DATA_W must be positive");
      end
   endgenerate

   logic [NPORT-1:0]             clk_v, rst_v, lo_v, hi_v, wrn_v, oen_v, pipe_v;
   logic [NPORT-1:0]             we_v, drv_v;
   logic [NPORT-1:0][ADDR_W-1:0] addr_v, maddr_v;
   logic [NPORT-1:0][DATA_W-1:0] wd_v, mwd_v, mrd_v, rd_v;

   assign clk_v  = {b_clk, a_clk};
   assign rst_v  = {b_rst_n, a_rst_n};
   assign lo_v   = {b_en_lo_n, a_en_lo_n};
   assign hi_v   = {b_en_hi, a_en_hi};
   assign wrn_v  = {b_wr_n, a_wr_n};
   assign oen_v  = {b_oe_n, a_oe_n};
   assign pipe_v = {b_pipe, a_pipe};
   assign addr_v = {b_addr, a_addr};
   assign wd_v   = {b_wdata, a_wdata};

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         tcr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
            .clk       (clk_v[p]),
            .rst_n     (rst_v[p]),
            .en_lo_n   (lo_v[p]),
            .en_hi     (hi_v[p]),
            .wr_n      (wrn_v[p]),
            .addr      (addr_v[p]),
            .wdata     (wd_v[p]),
            .oe_n      (oen_v[p]),
            .pipe      (pipe_v[p]),
            .mem_we    (we_v[p]),
            .mem_addr  (maddr_v[p]),
            .mem_wdata (mwd_v[p]),
            .mem_rdata (mrd_v[p]),
            .rdata     (rd_v[p]),
            .drive     (drv_v[p])
         );
      end
   endgenerate

   tcr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
      .clk_v   (clk_v),
      .we_v    (we_v),
      .addr_v  (maddr_v),
      .wdata_v (mwd_v),
      .rdata_v (mrd_v)
   );

   assign a_rdata = rd_v[0];
   assign b_rdata = rd_v[1];
   assign a_drive = drv_v[0];
   assign b_drive = drv_v[1];

endmodule

// File: tb/twinclk_ram_tb_top.sv
module twinclk_ram_tb_top;
   localparam int AW = 6;
   localparam int DW = 9;
   localparam int N  = 1 << AW;

   logic a_clk = 1'b0;
   logic b_clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 a_clk = ~a_clk;
   initial begin
      #5;
      forever #10 b_clk = ~b_clk;
   end

   logic          a_lo = 1'b1, a_hi = 1'b0, a_wn = 1'b1, a_oe_n = 1'b0, a_pipe = 1'b0;
   logic          b_lo = 1'b1, b_hi = 1'b0, b_wn = 1'b1, b_oe_n = 1'b0, b_pipe = 1'b0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wd = '0, b_wd = '0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic          a_drive, b_drive;

   twinclk_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .a_clk(a_clk), .a_rst_n(rst_n), .a_en_lo_n(a_lo), .a_en_hi(a_hi),
      .a_wr_n(a_wn), .a_addr(a_addr), .a_wdata(a_wd), .a_oe_n(a_oe_n),
      .a_pipe(a_pipe), .a_rdata(a_rdata), .a_drive(a_drive),
      .b_clk(b_clk), .b_rst_n(rst_n), .b_en_lo_n(b_lo), .b_en_hi(b_hi),
      .b_wr_n(b_wn), .b_addr(b_addr), .b_wdata(b_wd), .b_oe_n(b_oe_n),
      .b_pipe(b_pipe), .b_rdata(b_rdata), .b_drive(b_drive)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 37 + 5) % 512);
   endfunction

   task automatic a_drv(input logic lo, input logic hi, input logic wn, input int ad, input logic [DW-1:0] d);
      a_lo = lo; a_hi = hi; a_wn = wn; a_addr = AW'(ad); a_wd = d;
   endtask
   task automatic b_drv(input logic lo, input logic hi, input logic wn, input int ad, input logic [DW-1:0] d);
      b_lo = lo; b_hi = hi; b_wn = wn; b_addr = AW'(ad); b_wd = d;
   endtask
   task automatic a_nx(); @(negedge a_clk); endtask
   task automatic b_nx(); @(negedge b_clk); endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R10 reset state
      repeat (3) a_nx();
      chk("R10 a_drive", a_drive, 0);
      chk("R10 a_rdata", a_rdata, 0);
      chk("R10 b_drive", b_drive, 0);
      chk("R10 b_rdata", b_rdata, 0);
      rst_n = 1'b1;

      // R2 fill every word from port A, R7 no drive after writes
      for (int i = 0; i < N; i++) begin
         a_drv(0, 1, 0, i, pat(i));
         a_nx();
         chk("R7 write no drive", a_drive, 0);
      end
      // R3 flow-through readback on A
      for (int i = 0; i < N; i++) begin
         a_drv(0, 1, 1, i, '0);
         a_nx();
         chk("R3 ft drive", a_drive, 1);
         chk("R2 R3 ft data", a_rdata, pat(i));
      end
      a_drv(1, 0, 1, 0, '0);
      a_nx();
      chk("R5 ft deselect", a_drive, 0);
      chk("R8 zero when idle", a_rdata, 0);

      // R4 pipelined readback on B
      b_pipe = 1'b1;
      b_nx();
      for (int i = 0; i < N; i++) begin
         b_drv(0, 1, 1, i, '0);
         b_nx();
         if (i == 0) chk("R4 pipe first edge", b_drive, 0);
         else begin
            chk("R4 pipe drive", b_drive, 1);
            chk("R4 pipe data", b_rdata, pat(i - 1));
         end
      end
      b_drv(1, 1, 1, 0, '0);
      b_nx();
      chk("R5 pipe desel edge1 drive", b_drive, 1);
      chk("R4 pipe last data", b_rdata, pat(N - 1));
      b_nx();
      chk("R5 pipe desel edge2 drive", b_drive, 0);
      chk("R8 pipe idle zero", b_rdata, 0);
      // R5 pipelined reselect
      b_drv(0, 1, 1, 10, '0);
      b_nx();
      chk("R5 pipe reselect edge1", b_drive, 0);
      b_drv(0, 1, 1, 11, '0);
      b_nx();
      chk("R5 pipe reselect edge2", b_drive, 1);
      chk("R5 pipe reselect data", b_rdata, pat(10));
      // R11 mode switches without a clock
      #3 b_pipe = 1'b0;
      #1 chk("R11 to flow data", b_rdata, pat(11));
      chk("R11 to flow drive", b_drive, 1);
      b_pipe = 1'b1;
      #1 chk("R11 back to pipe", b_rdata, pat(10));
      // R6 output enable without a clock
      #1 b_oe_n = 1'b1;
      #1 chk("R6 oe off drive", b_drive, 0);
      chk("R6 oe off data", b_rdata, 0);
      b_oe_n = 1'b0;
      #1 chk("R6 oe back drive", b_drive, 1);
      b_drv(1, 0, 1, 0, '0);
      b_nx();
      b_nx();

      // R1 three deselecting encodings block writes
      a_drv(0, 1, 1, 3, '0);
      a_nx();
      chk("R1 selected read", a_drive, 1);
      a_drv(1, 1, 0, 5, 9'h0AA);
      a_nx();
      chk("R1 enc 11 no drive", a_drive, 0);
      a_drv(0, 0, 0, 5, 9'h0AA);
      a_nx();
      chk("R1 enc 00 no drive", a_drive, 0);
      a_drv(1, 0, 0, 5, 9'h0AA);
      a_nx();
      chk("R1 enc 10 no drive", a_drive, 0);
      a_drv(0, 1, 1, 5, '0);
      a_nx();
      chk("R5 ft reselect one edge", a_drive, 1);
      chk("R1 word unchanged", a_rdata, pat(5));

      // R7 flow-through read then write
      a_drv(0, 1, 1, 1, '0);
      a_nx();
      chk("R7 ft read before write", a_rdata, pat(1));
      a_drv(0, 1, 0, 4, pat(4));
      a_nx();
      chk("R7 ft after write drive", a_drive, 0);
      a_drv(1, 0, 1, 0, '0);

      // R7 pipelined read then write
      b_nx();
      b_drv(0, 1, 1, 1, '0);
      b_nx();
      b_drv(0, 1, 0, 2, pat(2));
      b_nx();
      chk("R7 pipe read still out", b_drive, 1);
      chk("R7 pipe read data", b_rdata, pat(1));
      b_drv(1, 0, 1, 0, '0);
      b_nx();
      chk("R7 pipe after write drive", b_drive, 0);

      // R9 A writes, B reads after
      b_pipe = 1'b0;
      a_nx();
      a_drv(0, 1, 0, 7, 9'h155);
      a_nx();
      a_drv(1, 0, 1, 0, '0);
      b_nx();
      b_drv(0, 1, 1, 7, '0);
      b_nx();
      chk("R9 B sees A write", b_rdata, 9'h155);
      // R9 B writes, A reads after
      b_drv(0, 1, 0, 8, 9'h0F3);
      b_nx();
      b_drv(1, 0, 1, 0, '0);
      a_nx();
      a_drv(0, 1, 1, 8, '0);
      a_nx();
      chk("R9 A sees B write", a_rdata, 9'h0F3);
      // R9 rewrite from A wins over the B word
      a_drv(0, 1, 0, 8, 9'h01C);
      a_nx();
      a_drv(0, 1, 1, 8, '0);
      a_nx();
      chk("R9 A rewrite wins", a_rdata, 9'h01C);
      // R9 concurrent read of one word
      b_nx();
      b_drv(0, 1, 1, 7, '0);
      a_nx();
      a_drv(0, 1, 1, 7, '0);
      a_nx();
      chk("R9 concurrent A", a_rdata, 9'h155);
      b_nx();
      chk("R9 concurrent B", b_rdata, 9'h155);
      a_drv(1, 0, 1, 0, '0);
      b_drv(1, 0, 1, 0, '0);
      a_nx();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule